// File: doc/BRIEF.md
# 4x4 Residual Coefficient Dequantizer

This block rescales one 4x4 block of signed 16-bit transform coefficients by a quantization parameter (QP) in a single transfer. QP is split into a shift, equal to QP divided by 6, and a period, equal to QP modulo 6. The period picks three base factors from a constant six-row table, and each factor is shifted left by the shift amount. Each coefficient is multiplied by one of those three scaled factors. The factor is chosen by the parity of the coefficient's row and column, and only the low 16 bits of each product are kept.

The whole block goes into the datapath at once and comes out of a single output register. A valid/ready handshake sits on both the input side and the output side. Inside the block, coefficients are handled as pairs packed into 32-bit words. The block sits between coefficient unpacking and the inverse transform.

Top module: `dequant4x4`

## Requirements
- R1: During reset and in the first cycle after it, out_valid_o is low and in_ready_o is high.
- R2: For QP in 0..51, the scaled factors are base << (QP/6). The base factor comes from row QP%6 of the class-ordered table: class EE = {10,11,13,14,16,18}, class OO = {16,18,20,23,25,29}, class MIX = {13,14,16,18,20,23}.
- R3: Coefficient k sits at bits [16k+15:16k] of the block, with row k/4 and column k%4. If the row and column are both even, the coefficient is class EE. If both are odd, it is class OO. Every other position is class MIX. For example, k=0 is EE, k=1 and k=4 are MIX, and k=5 is OO.
- R4: Coefficients are two's complement. Each output is the low 16 bits of coefficient × scaled factor, so overflow wraps and does not saturate.
- R5: Each accepted block (in_valid_i and in_ready_o high at a clock edge) produces exactly one output transfer, and blocks leave in the order they arrived. If the output register is empty or being drained, the result is on coef_o with out_valid_o high after the edge that accepts the block.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high, coef_o stays unchanged, and in_ready_o is low.
- R7: in_ready_o is high exactly when the output register is empty or out_ready_i is high, so a block can be accepted in the same cycle another leaves.
- R8: qp_i must be at most 51 whenever in_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Block can accept input |
| qp_i | input | 6 | Quantization parameter, 0..51 |
| coef_i | input | 256 | 16 input coefficients, k at bits 16k+:16 |
| out_valid_o | output | 1 | Output block valid |
| out_ready_i | input | 1 | Downstream accepts output |
| coef_o | output | 256 | 16 scaled coefficients, same layout |

## Verification
Every result is due exactly one clock edge after its block is accepted, because the only register on the path is the output register. in_ready_o is combinational and depends on that register and on out_ready_i. The bench keeps a behavioural model that is updated on each rising edge from the inputs the bench drove. On each falling edge it compares out_valid_o, in_ready_o and all 16 coefficients against the model, so a result that arrives a cycle early or late, or a block that is dropped, shows up as a mismatch in that same cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int unsigned COEF_W  = 16;
  localparam int unsigned N_COEF  = 16;
  localparam int unsigned ROW_LEN = 4;
  localparam int unsigned QP_W    = 6;
  localparam int unsigned FACT_W  = 16;
  localparam int unsigned SH_W    = 4;
  localparam int unsigned PER_W   = 3;
  localparam int unsigned QP_MAX  = 51;

  typedef enum logic [1:0] {CLS_EE = 2'd0, CLS_OO = 2'd1, CLS_MIX = 2'd2} cls_e;

  function automatic logic [4:0] base_factor(input logic [PER_W-1:0] per, input cls_e c);
    logic [4:0] v;
    case (per)
      3'd0:    v = (c == CLS_EE) ? 5'd10 : (c == CLS_OO) ? 5'd16 : 5'd13;
      3'd1:    v = (c == CLS_EE) ? 5'd11 : (c == CLS_OO) ? 5'd18 : 5'd14;
      3'd2:    v = (c == CLS_EE) ? 5'd13 : (c == CLS_OO) ? 5'd20 : 5'd16;
      3'd3:    v = (c == CLS_EE) ? 5'd14 : (c == CLS_OO) ? 5'd23 : 5'd18;
      3'd4:    v = (c == CLS_EE) ? 5'd16 : (c == CLS_OO) ? 5'd25 : 5'd20;
      default: v = (c == CLS_EE) ? 5'd18 : (c == CLS_OO) ? 5'd29 : 5'd23;
    endcase
    return v;
  endfunction

  function automatic cls_e pos_class(input int unsigned k);
    logic r_odd, c_odd;
    r_odd = ((k / ROW_LEN) % 2) == 1;
    c_odd = ((k % ROW_LEN) % 2) == 1;
    if (!r_odd && !c_odd) return CLS_EE;
    if (r_odd && c_odd)   return CLS_OO;
    return CLS_MIX;
  endfunction
endpackage

// File: rtl/dq_qp_split.sv
module dq_qp_split
  import dq_pkg::*;
#(
  parameter int unsigned QW  = QP_W,
  parameter int unsigned SW  = SH_W,
  parameter int unsigned PW  = PER_W,
  parameter int unsigned MAX = QP_MAX
) (
  input  logic [QW-1:0] qp_i,
  output logic [SW-1:0] shift_o,
  output logic [PW-1:0] period_o
);
  localparam int unsigned N_STEP = MAX / 6;

  logic [QW-1:0] base;

  // compare chain instead of a divider
  always_comb begin
    shift_o = '0;
    base    = '0;
    for (int unsigned i = 1; i <= N_STEP; i++) begin
      if (qp_i >= QW'(6 * i)) begin
        shift_o = SW'(i);
        base    = QW'(6 * i);
      end
    end
    period_o = PW'(qp_i - base);
  end
endmodule

// File: rtl/dq_factor_gen.sv
module dq_factor_gen
  import dq_pkg::*;
#(
  parameter int unsigned FW = FACT_W,
  parameter int unsigned SW = SH_W,
  parameter int unsigned PW = PER_W
) (
  input  logic [PW-1:0]         period_i,
  input  logic [SW-1:0]         shift_i,
  output logic [2:0][FW-1:0]    fact_o
);
  localparam cls_e CLS_LIST [3] = '{CLS_EE, CLS_OO, CLS_MIX};

  for (genvar c = 0; c < 3; c++) begin : g_cls
    assign fact_o[c] = FW'(base_factor(period_i, CLS_LIST[c])) << shift_i;
  end
endmodule

// File: rtl/dq_pair.sv
module dq_pair
  import dq_pkg::*;
#(
  parameter int unsigned CW  = COEF_W,
  parameter int unsigned FW  = FACT_W,
  parameter int unsigned IDX = 0
) (
  input  logic [2*CW-1:0]       word_i,
  input  logic [2:0][FW-1:0]    fact_i,
  output logic [2*CW-1:0]       word_o
);
  localparam int unsigned PRW = CW + FW + 1;

  for (genvar j = 0; j < 2; j++) begin : g_lane
    localparam cls_e CLS = pos_class(2 * IDX + j);
    logic signed [CW-1:0]  coef;
    logic signed [FW:0]    fact;
    logic signed [PRW-1:0] prod;
    assign coef = word_i[j*CW +: CW];
    assign fact = {1'b0, fact_i[CLS]};
    assign prod = PRW'(coef) * PRW'(fact);
    assign word_o[j*CW +: CW] = prod[CW-1:0];
  end
endmodule

// File: rtl/dequant4x4.sv
module dequant4x4
  import dq_pkg::*;
#(
  parameter int unsigned CW = COEF_W,
  parameter int unsigned NC = N_COEF,
  parameter int unsigned QW = QP_W,
  parameter int unsigned FW = FACT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [QW-1:0]    qp_i,
  input  logic [NC*CW-1:0] coef_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [NC*CW-1:0] coef_o
);
  localparam int unsigned NPAIR = NC / 2;
  localparam int unsigned WW    = 2 * CW;

  logic [SH_W-1:0]    shift;
  logic [PER_W-1:0]   period;
  logic [2:0][FW-1:0] fact;
  logic [NC*CW-1:0]   scaled;
  logic               accept;

  dq_qp_split #(.QW(QW)) u_split (
    .qp_i     (qp_i),
    .shift_o  (shift),
    .period_o (period)
  );

  dq_factor_gen #(.FW(FW)) u_fact (
    .period_i (period),
    .shift_i  (shift),
    .fact_o   (fact)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    dq_pair #(.CW(CW), .FW(FW), .IDX(p)) u_pair (
      .word_i (coef_i[p*WW +: WW]),
      .fact_i (fact),
      .word_o (scaled[p*WW +: WW])
    );
  end

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_o <= '0;
    end else if (accept) begin
      coef_o <= scaled;
    end
  end
endmodule

// File: rtl/dq_checker.sv
module dq_checker
  import dq_pkg::*;
#(
  parameter int unsigned CW = COEF_W,
  parameter int unsigned NC = N_COEF,
  parameter int unsigned QW = QP_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [QW-1:0]    qp_i,
  input logic [NC*CW-1:0] coef_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [NC*CW-1:0] coef_o
);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(coef_o));

  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_empty_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  p_accept_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  p_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_ready_i));

  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (coef_i == '0) |=> coef_o == '0);

  p_qp_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> qp_i <= QW'(QP_MAX));
endmodule

bind dequant4x4 dq_checker #(.CW(CW), .NC(NC), .QW(QW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .qp_i        (qp_i),
  .coef_i      (coef_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .coef_o      (coef_o)
);

// File: tb/tb_dequant4x4.sv
module tb_dequant4x4;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int N  = 16;
  localparam int BW = W * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [5:0]    qp_i = '0;
  logic [BW-1:0] coef_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b1;
  logic [BW-1:0] coef_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit bp_on = 0;
  bit done  = 0;

  bit          exp_v = 0;
  logic [BW-1:0] exp_d = '0;

  int t_ee [6] = '{10, 11, 13, 14, 16, 18};
  int t_oo [6] = '{16, 18, 20, 23, 25, 29};
  int t_mx [6] = '{13, 14, 16, 18, 20, 23};

  dequant4x4 dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [BW-1:0] ref_blk(input int qp, input logic [BW-1:0] c);
    logic [BW-1:0] r;
    for (int k = 0; k < N; k++) begin
      int row, col, f;
      longint prod;
      row = k / 4; col = k % 4;
      if (row % 2 == 0 && col % 2 == 0) f = t_ee[qp % 6];
      else if (row % 2 == 1 && col % 2 == 1) f = t_oo[qp % 6];
      else f = t_mx[qp % 6];
      f = f * (1 << (qp / 6));
      prod = longint'($signed(c[k*W +: W])) * longint'(f);
      r[k*W +: W] = prod[15:0];
    end
    return r;
  endfunction

  // reference model, updated from the inputs present at each edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_v = 0;
    else begin
      bit rdy;
      rdy = !exp_v || out_ready_i;
      if (exp_v && out_ready_i) exp_v = 0;
      if (in_valid_i && rdy) begin
        exp_v = 1;
        exp_d = ref_blk(int'(qp_i), coef_i);
      end
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      checks++;
      if (out_valid_o !== exp_v) begin
        fails++;
        $display("FAIL %s out_valid: got %b exp %b", (rst_ni ? "R5" : "R1"), out_valid_o, exp_v);
      end
      checks++;
      if (in_ready_o !== (!exp_v || out_ready_i)) begin
        fails++;
        $display("FAIL R7 in_ready: got %b exp %b", in_ready_o, (!exp_v || out_ready_i));
      end
      if (exp_v) begin
        checks++;
        if (coef_o !== exp_d) begin
          fails++;
          $display("FAIL %s coef_o: got %h exp %h", tag, coef_o, exp_d);
        end
      end
    end
  end

  // backpressure pattern
  always @(posedge clk_i) begin
    #1;
    if (bp_on) out_ready_i <= ($urandom % 3) != 0;
    else out_ready_i <= 1'b1;
  end

  task automatic send(input int qp, input logic [BW-1:0] c);
    bit acc;
    in_valid_i = 1'b1;
    qp_i = 6'(qp);
    coef_i = c;
    do begin
      @(negedge clk_i);
      acc = in_ready_o;
      @(posedge clk_i);
      #1;
    end while (!acc);
    in_valid_i = 1'b0;
  endtask

  function automatic logic [BW-1:0] rnd_blk();
    logic [BW-1:0] b;
    for (int k = 0; k < N; k++) b[k*W +: W] = W'($urandom);
    return b;
  endfunction

  function automatic logic [BW-1:0] fill(input logic [W-1:0] v);
    logic [BW-1:0] b;
    for (int k = 0; k < N; k++) b[k*W +: W] = v;
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R2, R5: all QP values, back to back
    tag = "R2";
    for (int q = 0; q <= 51; q++) send(q, rnd_blk());
    @(posedge clk_i); #1;

    // R3: unit coefficients expose the class pattern, QP 0 and 7
    tag = "R3";
    send(0, fill(16'd1));
    send(7, fill(16'd1));
    @(negedge clk_i);
    checks++;
    if (coef_o[0 +: 16] !== 16'd22 || coef_o[16 +: 16] !== 16'd28 ||
        coef_o[64 +: 16] !== 16'd28 || coef_o[80 +: 16] !== 16'd36) begin
      fails++;
      $display("FAIL R3 class pattern: got %h exp 22/28/28/36", coef_o[95:0]);
    end
    @(posedge clk_i); #1;

    // R4: wrap on overflow and negatives
    tag = "R4";
    send(51, fill(16'h7fff));
    send(51, fill(16'h8000));
    send(30, fill(16'hffff));
    send(45, rnd_blk());
    @(posedge clk_i); #1;

    // R6, R7: random backpressure and gaps
    tag = "R6";
    bp_on = 1;
    for (int i = 0; i < 60; i++) begin
      send(int'($urandom % 52), rnd_blk());
      repeat ($urandom % 3) @(posedge clk_i);
      #1;
    end
    bp_on = 0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule